// File: doc/BRIEF.md
# UART FIFO Interrupt Generator

This block turns the fill levels of a UART's receive and transmit FIFOs into interrupt requests. It also produces the identification code that software reads to find the cause, a data-ready status bit, and protection against writes into a full transmit FIFO. The FIFO storage, the serial shifters and the register file sit outside. They supply occupancy counts, push and pop strobes, the control bits, and strobes for a holding-register write and an identification-register read.

The receive request is a pure level function of the receive count against a selectable trigger. The transmit request is an event. It is raised when the transmit count newly enters its threshold region, which is either at most half full or fully empty. It is then acknowledged by a holding-register write or an identification read, and it stays low until the count enters the region again. A write that finds the transmit FIFO full is turned away, and a sticky overflow flag records it.

Top module: `uart_irq_gen`

## Requirements
- R1: With the FIFO-enable input or the receive-enable input low, the identification code never reads 0b0100 and the receive source does not drive the interrupt line.
- R2: With both enabled, the code reads 0b0100 and the interrupt line is high in every cycle in which the receive count is at or above the trigger. The trigger is selected by the 2-bit field: 0→1, 1→DEPTH/8, 2→DEPTH/4, 3→DEPTH/2 (1, 8, 16, 32 for 64 entries). When the count is below the trigger, the code is not 0b0100.
- R3: Data-ready goes high on the cycle after a receive push, and it is low whenever the receive count is zero.
- R4: With the FIFO-enable input or the transmit-enable input low, the code never reads 0b0010.
- R5: With the level-select bit at 0, a transmit request is raised one cycle after a clock edge where the count is at most DEPTH/2, provided the previous edge had the count above DEPTH/2 or was the first edge after reset. A count above DEPTH/2 removes the request at the next edge.
- R6: With the level-select bit at 1, the same rule applies with the condition "count is zero". A non-zero count removes the request at the next edge.
- R7: A holding-register write or an identification read removes a pending transmit request at the next edge. The request then stays low until the condition is newly entered.
- R8: A holding-register write while the transmit count equals DEPTH asserts the write-drop output in that cycle and sets the overflow flag at the next edge. An identification read clears the flag, but a new overflow in the same cycle wins.
- R9: The code is 0b0100 when receive is pending, else 0b0010 when transmit is pending, else 0b0001. The interrupt line is high exactly when the code is not 0b0001.
- R10: During and right after reset, the interrupt line, data-ready and overflow are low and the code reads 0b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable from the FIFO control register |
| tx_lvl_sel | input | 1 | Transmit threshold: 0 half-empty, 1 empty |
| rx_trig_sel | input | 2 | Receive trigger selection |
| ier_rx_en | input | 1 | Receive interrupt enable |
| ier_tx_en | input | 1 | Transmit interrupt enable |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_push | input | 1 | Character moved into receive FIFO |
| rx_pop | input | 1 | Character read from receive FIFO |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| thr_wr | input | 1 | Holding-register write strobe |
| iir_rd | input | 1 | Identification-register read strobe |
| irq | output | 1 | Combined interrupt request |
| iir_code | output | 4 | Identification code |
| data_ready | output | 1 | Receive data present |
| tx_overflow | output | 1 | Sticky transmit overflow flag |
| tx_wr_drop | output | 1 | Current write must be discarded |

## Verification
The bench builds the block with DEPTH=64, which makes CNT_W 7. The largest trigger (32), the half-empty mark and the full condition at 64 can each be reached by pushes alone within a few dozen cycles. With that size, the random phase crosses every receive trigger, crosses the half-empty mark in both directions and hits the full transmit FIFO many times in a few thousand cycles. The directed part also covers acknowledge and re-arm ordering, and receive-over-transmit priority.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [3:0] {
      IID_NONE = 4'b0001,
      IID_TX   = 4'b0010,
      IID_RX   = 4'b0100
   } iid_e;

   function automatic int cnt_width(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/uart_irq_rx.sv
module uart_irq_rx #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             src_en,
   input  logic [1:0]       trig_sel,
   input  logic [CNT_W-1:0] count,
   input  logic             push,
   input  logic             pop,
   output logic             req,
   output logic             data_ready
);
   localparam int NUM_TRIG = 4;

   logic [CNT_W-1:0] thr_tab [NUM_TRIG];
   logic             dr_q;

   // trigger table: one character, then DEPTH/8, DEPTH/4, DEPTH/2
   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_thr
      if (g == 0) begin : g_single
         assign thr_tab[g] = CNT_W'(1);
      end else begin : g_frac
         assign thr_tab[g] = CNT_W'(DEPTH >> (NUM_TRIG - g));
      end
   end

   assign req = fifo_en & src_en & (count >= thr_tab[trig_sel]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dr_q <= 1'b0;
      end else if (push) begin
         dr_q <= 1'b1;
      end else if (count == '0 || (pop && count == CNT_W'(1))) begin
         dr_q <= 1'b0;
      end
   end

   assign data_ready = dr_q;
endmodule

// File: rtl/uart_irq_tx.sv
module uart_irq_tx #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             src_en,
   input  logic             lvl_sel,
   input  logic [CNT_W-1:0] count,
   input  logic             thr_wr,
   input  logic             iir_rd,
   output logic             req,
   output logic             overflow,
   output logic             wr_drop
);
   localparam int HALF = DEPTH / 2;

   logic cond, cond_q, pend_q, ack, full, ovf_q;

   assign cond = lvl_sel ? (count == '0) : (count <= CNT_W'(HALF));
   assign ack  = thr_wr | iir_rd;
   assign full = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         pend_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         cond_q <= cond;
         // raise on entry into the region, hold while inside, drop on ack
         pend_q <= cond & ~ack & (pend_q | ~cond_q);
         if (thr_wr && full) begin
            ovf_q <= 1'b1;
         end else if (iir_rd) begin
            ovf_q <= 1'b0;
         end
      end
   end

   assign req      = fifo_en & src_en & pend_q;
   assign overflow = ovf_q;
   assign wr_drop  = thr_wr & full;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic       rx_req,
   input  logic       tx_req,
   output logic [3:0] code,
   output logic       irq
);
   iid_e sel;

   always_comb begin
      if (rx_req) begin
         sel = IID_RX;
      end else if (tx_req) begin
         sel = IID_TX;
      end else begin
         sel = IID_NONE;
      end
   end

   assign code = sel;
   assign irq  = rx_req | tx_req;
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
   import uart_irq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CNT_W = cnt_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             tx_lvl_sel,
   input  logic [1:0]       rx_trig_sel,
   input  logic             ier_rx_en,
   input  logic             ier_tx_en,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic [CNT_W-1:0] tx_count,
   input  logic             thr_wr,
   input  logic             iir_rd,
   output logic             irq,
   output logic [3:0]       iir_code,
   output logic             data_ready,
   output logic             tx_overflow,
   output logic             tx_wr_drop
);
   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_irq_gen: DEPTH must be a power of two of at least 8");
   end

   logic rx_req, tx_req;

   uart_irq_rx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_en    (fifo_en),
      .src_en     (ier_rx_en),
      .trig_sel   (rx_trig_sel),
      .count      (rx_count),
      .push       (rx_push),
      .pop        (rx_pop),
      .req        (rx_req),
      .data_ready (data_ready)
   );

   uart_irq_tx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_en  (fifo_en),
      .src_en   (ier_tx_en),
      .lvl_sel  (tx_lvl_sel),
      .count    (tx_count),
      .thr_wr   (thr_wr),
      .iir_rd   (iir_rd),
      .req      (tx_req),
      .overflow (tx_overflow),
      .wr_drop  (tx_wr_drop)
   );

   uart_irq_prio u_prio (
      .rx_req (rx_req),
      .tx_req (tx_req),
      .code   (iir_code),
      .irq    (irq)
   );
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_en,
   input logic             tx_lvl_sel,
   input logic [1:0]       rx_trig_sel,
   input logic             ier_rx_en,
   input logic             ier_tx_en,
   input logic [CNT_W-1:0] rx_count,
   input logic             rx_push,
   input logic [CNT_W-1:0] tx_count,
   input logic             thr_wr,
   input logic             iir_rd,
   input logic             irq,
   input logic [3:0]       iir_code,
   input logic             data_ready,
   input logic             tx_overflow,
   input logic             tx_wr_drop
);
   logic [CNT_W-1:0] trig;
   always_comb begin
      case (rx_trig_sel)
         2'd0:    trig = CNT_W'(1);
         2'd1:    trig = CNT_W'(DEPTH / 8);
         2'd2:    trig = CNT_W'(DEPTH / 4);
         default: trig = CNT_W'(DEPTH / 2);
      endcase
   end

   assert_rx_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_en && ier_rx_en) |-> iir_code != 4'b0100);

   assert_rx_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && ier_rx_en && rx_count >= trig) |-> (iir_code == 4'b0100 && irq));

   assert_rx_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count < trig) |-> iir_code != 4'b0100);

   assert_dr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> data_ready);

   assert_dr_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == '0) |-> !data_ready);

   assert_tx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_en && ier_tx_en) |-> iir_code != 4'b0010);

   assert_tx_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_lvl_sel && tx_count > CNT_W'(DEPTH / 2)) |=> iir_code != 4'b0010);

   assert_tx_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lvl_sel && tx_count != '0) |=> iir_code != 4'b0010);

   assert_tx_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr || iir_rd) |=> iir_code != 4'b0010);

   assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && tx_count == CNT_W'(DEPTH)) |-> tx_wr_drop);

   assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr_drop |=> tx_overflow);

   assert_code_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(iir_code) == 1 && irq == (iir_code != 4'b0001));

   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |=> (!irq && iir_code == 4'b0001 && !data_ready && !tx_overflow));
endmodule

bind uart_irq_gen uart_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fifo_en     (fifo_en),
   .tx_lvl_sel  (tx_lvl_sel),
   .rx_trig_sel (rx_trig_sel),
   .ier_rx_en   (ier_rx_en),
   .ier_tx_en   (ier_tx_en),
   .rx_count    (rx_count),
   .rx_push     (rx_push),
   .tx_count    (tx_count),
   .thr_wr      (thr_wr),
   .iir_rd      (iir_rd),
   .irq         (irq),
   .iir_code    (iir_code),
   .data_ready  (data_ready),
   .tx_overflow (tx_overflow),
   .tx_wr_drop  (tx_wr_drop)
);

// File: tb/uart_irq_gen_tb.sv
module uart_irq_gen_tb;
   localparam int DEPTH = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_en = 1'b0, tx_lvl_sel = 1'b0, ier_rx_en = 1'b0, ier_tx_en = 1'b0;
   logic [1:0] rx_trig_sel = 2'd0;
   logic rx_push = 1'b0, rx_pop = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0;
   logic drain = 1'b0;
   int   rx_cnt = 0, tx_cnt = 0;
   logic [6:0] rx_count, tx_count;
   logic irq, data_ready, tx_overflow, tx_wr_drop;
   logic [3:0] iir_code;

   int total = 0, bad = 0;
   bit done = 0;
   string tag = "R10";

   // bench model state
   bit m_cond_q, m_pend, m_dr, m_ovf, cond;

   assign rx_count = 7'(rx_cnt);
   assign tx_count = 7'(tx_cnt);

   always #5 clk = ~clk;

   uart_irq_gen #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_lvl_sel(tx_lvl_sel),
      .rx_trig_sel(rx_trig_sel), .ier_rx_en(ier_rx_en), .ier_tx_en(ier_tx_en),
      .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
      .tx_count(tx_count), .thr_wr(thr_wr), .iir_rd(iir_rd),
      .irq(irq), .iir_code(iir_code), .data_ready(data_ready),
      .tx_overflow(tx_overflow), .tx_wr_drop(tx_wr_drop)
   );

   function automatic int trig_of(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 8;
         2'd2: return 16;
         default: return 32;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cond_q <= 0; m_pend <= 0; m_dr <= 0; m_ovf <= 0;
         rx_cnt <= 0; tx_cnt <= 0;
      end else begin
         cond = tx_lvl_sel ? (tx_cnt == 0) : (tx_cnt <= DEPTH / 2);
         m_pend   <= cond && !(thr_wr || iir_rd) && (m_pend || !m_cond_q);
         m_cond_q <= cond;
         if (rx_push) m_dr <= 1;
         else if (rx_cnt == 0 || (rx_pop && rx_cnt == 1)) m_dr <= 0;
         if (thr_wr && tx_cnt == DEPTH) m_ovf <= 1;
         else if (iir_rd) m_ovf <= 0;
         rx_cnt <= rx_cnt + (rx_push ? 1 : 0) - (rx_pop ? 1 : 0);
         tx_cnt <= tx_cnt + ((thr_wr && tx_cnt < DEPTH) ? 1 : 0) - (drain ? 1 : 0);
      end
   end

   task automatic chk(input string t, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      bit rx_p, tx_p;
      int code;
      rx_p = fifo_en && ier_rx_en && (rx_cnt >= trig_of(rx_trig_sel));
      tx_p = fifo_en && ier_tx_en && m_pend;
      code = rx_p ? 4 : (tx_p ? 2 : 1);
      chk(tag, "iir_code", int'(iir_code), code);
      chk(tag, "irq", int'(irq), int'(rx_p || tx_p));
      chk(tag, "data_ready", int'(data_ready), int'(m_dr));
      chk(tag, "tx_overflow", int'(tx_overflow), int'(m_ovf));
      chk(tag, "tx_wr_drop", int'(tx_wr_drop), int'(thr_wr && tx_cnt == DEPTH));
   endtask

   task automatic step(input bit p, input bit q, input bit w, input bit r, input bit d);
      rx_push = p && (rx_cnt < DEPTH);
      rx_pop  = q && (rx_cnt > 0);
      thr_wr  = w;
      iir_rd  = r;
      drain   = d && (tx_cnt > 0);
      #2;
      cmp_model();
      @(posedge clk);
      #1;
      rx_push = 0; rx_pop = 0; thr_wr = 0; iir_rd = 0; drain = 0;
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7531));
      // R10 reset state
      repeat (3) @(posedge clk);
      #2;
      chk("R10", "irq", int'(irq), 0);
      chk("R10", "iir_code", int'(iir_code), 1);
      chk("R10", "data_ready", int'(data_ready), 0);
      chk("R10", "tx_overflow", int'(tx_overflow), 0);
      fifo_en = 1; ier_tx_en = 1; tx_lvl_sel = 1;
      @(posedge clk); #1 rst_n = 1; #1;

      // R6: empty FIFO after reset raises transmit request
      tag = "R6";
      step(0, 0, 0, 0, 0);
      chk("R6", "iir_code", int'(iir_code), 2);
      // R7: read acknowledges, stays low while condition persists
      tag = "R7";
      step(0, 0, 0, 1, 0);
      chk("R7", "iir_code", int'(iir_code), 1);
      repeat (3) step(0, 0, 0, 0, 0);
      chk("R7", "iir_code held low", int'(iir_code), 1);

      // R2: trigger of 8
      tag = "R2";
      ier_rx_en = 1; rx_trig_sel = 2'd1;
      repeat (7) step(1, 0, 0, 0, 0);
      chk("R2", "iir_code at 7", int'(iir_code), 1);
      step(1, 0, 0, 0, 0);
      chk("R2", "iir_code at 8", int'(iir_code), 4);

      // R9: both pending, receive wins
      tag = "R9";
      step(0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0);
      chk("R9", "iir_code both", int'(iir_code), 4);
      step(0, 1, 0, 0, 0);
      chk("R9", "iir_code tx only", int'(iir_code), 2);

      // R1: FIFO disable masks receive source
      tag = "R1";
      rx_trig_sel = 2'd0; fifo_en = 0; #1;
      chk("R1", "iir_code", int'(iir_code), 1);
      chk("R1", "irq", int'(irq), 0);
      fifo_en = 1; #1;
      chk("R2", "iir_code re-enabled", int'(iir_code), 4);

      // R3: drain receive FIFO
      tag = "R3";
      repeat (7) step(0, 1, 0, 0, 0);
      chk("R3", "data_ready empty", int'(data_ready), 0);
      step(1, 0, 0, 0, 0);
      chk("R3", "data_ready push", int'(data_ready), 1);
      step(0, 1, 0, 0, 0);

      // R5: half-empty threshold
      tag = "R5";
      tx_lvl_sel = 0;
      step(0, 0, 0, 1, 0);
      repeat (40) step(0, 0, 1, 0, 0);
      chk("R5", "iir_code above half", int'(iir_code), 1);
      repeat (8) step(0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0);
      chk("R5", "iir_code at half", int'(iir_code), 2);
      step(0, 0, 1, 0, 0);
      chk("R7", "iir_code after write", int'(iir_code), 1);

      // R8: overflow on full FIFO
      tag = "R8";
      while (tx_cnt < DEPTH) step(0, 0, 1, 0, 0);
      thr_wr = 1; #1;
      chk("R8", "tx_wr_drop", int'(tx_wr_drop), 1);
      step(0, 0, 1, 0, 0);
      chk("R8", "tx_overflow set", int'(tx_overflow), 1);
      step(0, 0, 0, 1, 0);
      chk("R8", "tx_overflow cleared", int'(tx_overflow), 0);
      thr_wr = 1; iir_rd = 1; #1;
      step(0, 0, 1, 1, 0);
      chk("R8", "tx_overflow set wins", int'(tx_overflow), 1);

      // R4: transmit source masked
      tag = "R4";
      ier_tx_en = 0;
      for (int i = 0; i < 800; i++) begin
         if (($urandom % 64) == 0) tx_lvl_sel = $urandom % 2;
         step($urandom % 2, ($urandom % 3) == 0, ($urandom % 3) == 0,
              ($urandom % 16) == 0, $urandom % 2);
         if (iir_code == 4'b0010) chk("R4", "iir_code masked", int'(iir_code), 1);
      end

      // mixed random traffic, all sources enabled
      tag = "R9 random";
      ier_tx_en = 1;
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 50) == 0) rx_trig_sel = 2'($urandom % 4);
         if (($urandom % 80) == 0) tx_lvl_sel = $urandom % 2;
         if (($urandom % 200) == 0) fifo_en = ~fifo_en;
         step(($urandom % 5) < 2, ($urandom % 5) < 2, ($urandom % 5) < 3,
              ($urandom % 20) == 0, ($urandom % 5) < 2);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule